// File: doc/BRIEF.md
# Truth Table Composition Engine

This engine builds the truth table of a new Boolean function by composing a two-input operation with the functions that feed its operands. Each operand is described by a kind and an argument. It can be a constant bit, a live register bit bound to one of the global variable identifiers, or a function already held in the engine's internal repository. A repository function is a 64-entry table together with the set of variables it depends on.

After `start_i`, the engine merges the operands' variable sets. If the selected library operation asks for one, it also adds a carry variable. It then walks every combination of the merged variables, one per clock. For each combination it first looks up both operand tables. It then indexes the operation's 8-entry library table with the carry, B and A bits. When the walk ends, it writes the finished table and its variable set into the next free repository slot and returns that slot's index together with the table. A later composition can name that index as a function operand, so functions are built up step by step.

Top module: `tt_compose_engine`

## Requirements
- R1: After reset `busy_o`, `done_o` and `reject_o` are low, and the first accepted composition is stored at index 0.
- R2: Operand kinds are encoded 0 = constant, 1 = live variable, 2 = repository function. A constant takes `arg[0]` for every combination. A variable operand equals the variable whose identifier is `arg`. A function operand is evaluated from the table stored at index `arg`.
- R3: The result's variable set (`vars_o`, one bit per identifier) is the union of the operand sets plus any carry variable. Bit j of the table index is the j-th lowest identifier in the set. `count_o` is the set size, and table bits at positions of 2^count and above are zero.
- R4: For each combination the result bit is `lib[{c,b,a}]`. Here a and b are the operand values, and c is the carry variable's value, or 0 when the operation adds none. The library is: 0 AND, 1 OR, 2 XOR, 3 A AND NOT B, 4 SUM (a^b^c), 5 CARRY (majority), 6 NOT A, 7 SELECT (c ? b : a).
- R5: Operations 4, 5 and 7 add the variable named by `carry_var_i` to the variable set. The other operations add nothing.
- R6: Take the edge that samples `start_i` as the first edge. An accepted composition with k inputs raises `done_o` for one cycle after the (2^k+2)-th rising edge.
- R7: If the merged set holds more than 6 variables, `done_o` and `reject_o` rise after the first edge and nothing is written. The free index is not consumed.
- R8: When every repository slot is used, a start is rejected in the same way as in R7.
- R9: Result indices are handed out in ascending order from a free-slot counter.
- R10: `start_i` is ignored while `busy_o` is high, and the running composition's result is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a composition when idle |
| op_i | input | 3 | Library operation code |
| a_kind_i | input | 2 | Operand A kind |
| a_arg_i | input | ARG_W | Operand A constant, variable id or repository index |
| b_kind_i | input | 2 | Operand B kind |
| b_arg_i | input | ARG_W | Operand B constant, variable id or repository index |
| carry_var_i | input | VAR_W | Variable id used as carry input by carry operations |
| busy_o | output | 1 | Composition in progress |
| done_o | output | 1 | One-cycle completion pulse |
| reject_o | output | 1 | With `done_o`: request refused, nothing stored |
| index_o | output | IDX_W | Repository index of the stored result |
| count_o | output | CNT_W | Number of inputs of the result |
| vars_o | output | NVARS | Variable set of the result |
| table_o | output | 2^MAX_IN | Result truth table |

## Verification
Two events can share a cycle. One is a new `start_i` that arrives while the evaluation walk is still running. The other is a start presented in the very cycle that `done_o` is shown. The bench pulses a start with different operands in the middle of the 64-combination walk and expects the original table, index and latency. Every later scenario drives its start in the cycle that the previous done is visible, including the start right after a reject. Those compositions must be accepted at once and must receive the index that the reject left unused.

// File: rtl/ttc_pkg.sv
package ttc_pkg;
  localparam int OP_W = 3;

  typedef enum logic [1:0] {
    K_CONST = 2'd0,
    K_VAR   = 2'd1,
    K_FUNC  = 2'd2
  } kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EVAL,
    ST_WRITE
  } state_e;

  typedef struct packed {
    logic [7:0] tt;    // indexed by {c,b,a}
    logic       carry; // adds a carry variable
  } lib_ent_t;

  function automatic lib_ent_t lib_lookup(input logic [OP_W-1:0] op);
    lib_ent_t e;
    unique case (op)
      3'd0: e = '{tt: 8'b1000_1000, carry: 1'b0}; // and
      3'd1: e = '{tt: 8'b1110_1110, carry: 1'b0}; // or
      3'd2: e = '{tt: 8'b0110_0110, carry: 1'b0}; // xor
      3'd3: e = '{tt: 8'b0010_0010, carry: 1'b0}; // a & ~b
      3'd4: e = '{tt: 8'b1001_0110, carry: 1'b1}; // sum
      3'd5: e = '{tt: 8'b1110_1000, carry: 1'b1}; // carry out
      3'd6: e = '{tt: 8'b0101_0101, carry: 1'b0}; // not a
      default: e = '{tt: 8'b1100_1010, carry: 1'b1}; // c ? b : a
    endcase
    return e;
  endfunction
endpackage

// File: rtl/ttc_operand.sv
module ttc_operand
  import ttc_pkg::*;
#(
  parameter int NVARS = 16,
  parameter int TT_W  = 64,
  parameter int ARG_W = 4
) (
  input  logic [1:0]       kind_i,
  input  logic [ARG_W-1:0] arg_i,
  input  logic [NVARS-1:0] fn_mask_i,
  input  logic [TT_W-1:0]  fn_tt_i,
  output logic [NVARS-1:0] mask_o,
  output logic [TT_W-1:0]  tt_o
);
  always_comb begin
    unique case (kind_e'(kind_i))
      K_VAR: begin
        mask_o = NVARS'(1) << arg_i;
        tt_o   = TT_W'(2);      // index 1 -> 1
      end
      K_FUNC: begin
        mask_o = fn_mask_i;
        tt_o   = fn_tt_i;
      end
      default: begin
        mask_o = '0;
        tt_o   = {TT_W{arg_i[0]}};
      end
    endcase
  end
endmodule

// File: rtl/ttc_eval.sv
module ttc_eval #(
  parameter int NVARS  = 16,
  parameter int MAX_IN = 6,
  parameter int TT_W   = 64,
  parameter int VAR_W  = 4
) (
  input  logic [NVARS-1:0]  merged_i,
  input  logic [MAX_IN-1:0] n_i,
  input  logic [NVARS-1:0]  mask_a_i,
  input  logic [TT_W-1:0]   tt_a_i,
  input  logic [NVARS-1:0]  mask_b_i,
  input  logic [TT_W-1:0]   tt_b_i,
  input  logic              carry_en_i,
  input  logic [VAR_W-1:0]  carry_var_i,
  input  logic [7:0]        lib_tt_i,
  output logic              bit_o
);
  // scatter combination bits onto the merged variables
  function automatic logic [NVARS-1:0] deposit(input logic [NVARS-1:0] m,
                                               input logic [MAX_IN-1:0] n);
    logic [NVARS-1:0] r;
    int j;
    r = '0;
    j = 0;
    for (int i = 0; i < NVARS; i++) begin
      if (m[i]) begin
        if (j < MAX_IN) r[i] = n[j];
        j++;
      end
    end
    return r;
  endfunction

  // gather an operand's own variables into its table index
  function automatic logic [MAX_IN-1:0] gather(input logic [NVARS-1:0] asg,
                                               input logic [NVARS-1:0] m);
    logic [MAX_IN-1:0] r;
    int j;
    r = '0;
    j = 0;
    for (int i = 0; i < NVARS; i++) begin
      if (m[i]) begin
        if (j < MAX_IN) r[j] = asg[i];
        j++;
      end
    end
    return r;
  endfunction

  logic [NVARS-1:0] asg;
  logic a_bit, b_bit, c_bit;

  always_comb begin
    asg   = deposit(merged_i, n_i);
    a_bit = tt_a_i[gather(asg, mask_a_i)];
    b_bit = tt_b_i[gather(asg, mask_b_i)];
    c_bit = carry_en_i & asg[carry_var_i];
    bit_o = lib_tt_i[{c_bit, b_bit, a_bit}];
  end
endmodule

// File: rtl/tt_compose_engine.sv
module tt_compose_engine
  import ttc_pkg::*;
#(
  parameter int NVARS  = 16,
  parameter int MAX_IN = 6,
  parameter int DEPTH  = 16,
  localparam int TT_W  = 1 << MAX_IN,
  localparam int VAR_W = $clog2(NVARS),
  localparam int IDX_W = $clog2(DEPTH),
  localparam int ARG_W = (VAR_W > IDX_W) ? VAR_W : IDX_W,
  localparam int CNT_W = $clog2(MAX_IN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [1:0]        a_kind_i,
  input  logic [ARG_W-1:0]  a_arg_i,
  input  logic [1:0]        b_kind_i,
  input  logic [ARG_W-1:0]  b_arg_i,
  input  logic [VAR_W-1:0]  carry_var_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              reject_o,
  output logic [IDX_W-1:0]  index_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [NVARS-1:0]  vars_o,
  output logic [TT_W-1:0]   table_o
);
  logic [NVARS-1:0] repo_mask [DEPTH];
  logic [TT_W-1:0]  repo_tt   [DEPTH];

  state_e            st_q;
  lib_ent_t          lib_q;
  logic [NVARS-1:0]  ma_q, mb_q, merged_q;
  logic [TT_W-1:0]   ta_q, tb_q, acc_q;
  logic [VAR_W-1:0]  cvar_q;
  logic [CNT_W-1:0]  k_q;
  logic [MAX_IN-1:0] cnt_q, last_q;
  logic [IDX_W:0]    free_q;

  // repository reads for function operands
  logic [NVARS-1:0] fa_mask, fb_mask;
  logic [TT_W-1:0]  fa_tt, fb_tt;
  always_comb begin
    fa_mask = '0; fa_tt = '0; fb_mask = '0; fb_tt = '0;
    if (32'(a_arg_i) < DEPTH) begin
      fa_mask = repo_mask[a_arg_i[IDX_W-1:0]];
      fa_tt   = repo_tt[a_arg_i[IDX_W-1:0]];
    end
    if (32'(b_arg_i) < DEPTH) begin
      fb_mask = repo_mask[b_arg_i[IDX_W-1:0]];
      fb_tt   = repo_tt[b_arg_i[IDX_W-1:0]];
    end
  end

  logic [NVARS-1:0] ma_d, mb_d;
  logic [TT_W-1:0]  ta_d, tb_d;

  ttc_operand #(.NVARS(NVARS), .TT_W(TT_W), .ARG_W(ARG_W)) u_opa (
    .kind_i(a_kind_i), .arg_i(a_arg_i), .fn_mask_i(fa_mask), .fn_tt_i(fa_tt),
    .mask_o(ma_d), .tt_o(ta_d)
  );
  ttc_operand #(.NVARS(NVARS), .TT_W(TT_W), .ARG_W(ARG_W)) u_opb (
    .kind_i(b_kind_i), .arg_i(b_arg_i), .fn_mask_i(fb_mask), .fn_tt_i(fb_tt),
    .mask_o(mb_d), .tt_o(tb_d)
  );

  lib_ent_t         lib_d;
  logic [NVARS-1:0] merged_d;
  int               pop_d;
  logic             refuse_d;
  always_comb begin
    lib_d    = lib_lookup(op_i);
    merged_d = ma_d | mb_d | (lib_d.carry ? (NVARS'(1) << carry_var_i) : '0);
    pop_d    = $countones(merged_d);
    refuse_d = (pop_d > MAX_IN) || (32'(free_q) >= DEPTH);
  end

  logic res_bit;
  ttc_eval #(.NVARS(NVARS), .MAX_IN(MAX_IN), .TT_W(TT_W), .VAR_W(VAR_W)) u_eval (
    .merged_i(merged_q), .n_i(cnt_q),
    .mask_a_i(ma_q), .tt_a_i(ta_q), .mask_b_i(mb_q), .tt_b_i(tb_q),
    .carry_en_i(lib_q.carry), .carry_var_i(cvar_q), .lib_tt_i(lib_q.tt),
    .bit_o(res_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      lib_q    <= '0;
      ma_q     <= '0;
      mb_q     <= '0;
      ta_q     <= '0;
      tb_q     <= '0;
      merged_q <= '0;
      cvar_q   <= '0;
      k_q      <= '0;
      cnt_q    <= '0;
      last_q   <= '0;
      acc_q    <= '0;
      free_q   <= '0;
      done_o   <= 1'b0;
      reject_o <= 1'b0;
      index_o  <= '0;
      count_o  <= '0;
      vars_o   <= '0;
      table_o  <= '0;
    end else begin
      done_o   <= 1'b0;
      reject_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          if (refuse_d) begin
            done_o   <= 1'b1;
            reject_o <= 1'b1;
          end else begin
            lib_q    <= lib_d;
            ma_q     <= ma_d;
            mb_q     <= mb_d;
            ta_q     <= ta_d;
            tb_q     <= tb_d;
            merged_q <= merged_d;
            cvar_q   <= carry_var_i;
            k_q      <= CNT_W'(pop_d);
            last_q   <= MAX_IN'((1 << pop_d) - 1);
            cnt_q    <= '0;
            acc_q    <= '0;
            st_q     <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          acc_q[cnt_q] <= res_bit;
          cnt_q        <= cnt_q + 1'b1;
          if (cnt_q == last_q) st_q <= ST_WRITE;
        end
        default: begin
          index_o <= free_q[IDX_W-1:0];
          count_o <= k_q;
          vars_o  <= merged_q;
          table_o <= acc_q;
          free_q  <= free_q + 1'b1;
          done_o  <= 1'b1;
          st_q    <= ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (st_q == ST_WRITE) begin
      repo_mask[free_q[IDX_W-1:0]] <= merged_q;
      repo_tt[free_q[IDX_W-1:0]]   <= acc_q;
    end
  end

  assign busy_o = (st_q != ST_IDLE);

  p_idle_when_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_reject_flags_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |-> done_o);
  p_no_write_on_reject_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |-> $stable(free_q));
  p_count_limit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !reject_o) |-> (count_o <= CNT_W'(MAX_IN)));
  p_count_matches_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !reject_o) |-> ($countones(vars_o) == int'(count_o)));
  p_unused_rows_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !reject_o) |-> ((table_o >> (1 << count_o)) == '0));
  p_index_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !$past(busy_o)) |=> $stable(free_q) || (st_q == ST_IDLE));
endmodule

// File: tb/tt_compose_engine_test.sv
`timescale 1ns/1ps
module tt_compose_engine_test;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  a_kind = '0, b_kind = '0;
  logic [3:0]  a_arg = '0, b_arg = '0;
  logic [3:0]  cvar = '0;
  logic        busy, done, reject;
  logic [2:0]  index;
  logic [2:0]  count;
  logic [15:0] vars;
  logic [63:0] tbl;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  tt_compose_engine #(.NVARS(16), .MAX_IN(6), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .a_kind_i(a_kind), .a_arg_i(a_arg), .b_kind_i(b_kind), .b_arg_i(b_arg),
    .carry_var_i(cvar), .busy_o(busy), .done_o(done), .reject_o(reject),
    .index_o(index), .count_o(count), .vars_o(vars), .table_o(tbl)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one composition and judge its outcome
  task automatic run(input string tag, input logic [2:0] o,
                     input logic [1:0] ak, input logic [3:0] aa,
                     input logic [1:0] bk, input logic [3:0] ba,
                     input logic [3:0] cv, input bit poke, input bit exp_rej,
                     input logic [63:0] exp_tbl, input logic [15:0] exp_vars,
                     input int exp_cnt, input int exp_idx, input int exp_lat);
    int lat;
    op = o; a_kind = ak; a_arg = aa; b_kind = bk; b_arg = ba; cvar = cv;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 200) begin
      if (poke && lat == 3) begin
        start = 1'b1; op = 3'd1; a_kind = 2'd0; a_arg = 4'd1;
      end else begin
        start = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    check({tag, " R6 latency"}, 64'(lat), 64'(exp_lat));
    check({tag, " R7 reject"}, 64'(reject), 64'(exp_rej));
    if (!exp_rej) begin
      check({tag, " R9 index"}, 64'(index), 64'(exp_idx));
      check({tag, " R3 count"}, 64'(count), 64'(exp_cnt));
      check({tag, " R3 vars"}, 64'(vars), 64'(exp_vars));
      check({tag, " R4 table"}, tbl, exp_tbl);
    end
  endtask

  task automatic t_reset;
    check("R1 busy after reset", 64'(busy), 64'd0);
    check("R1 done after reset", 64'(done), 64'd0);
    check("R1 reject after reset", 64'(reject), 64'd0);
  endtask

  task automatic t_var_and;   // R1 R2: first index 0, two live variables
    run("r1_and_vars", 3'd0, 2'd1, 4'd2, 2'd1, 4'd5, 4'd0, 0, 0,
        64'h8, 16'h0024, 2, 0, 6);
  endtask

  task automatic t_func_xor;  // R2 function operand reuse
    run("r2_func_xor", 3'd2, 2'd2, 4'd0, 2'd1, 4'd0, 4'd0, 0, 0,
        64'h6A, 16'h0025, 3, 1, 10);
  endtask

  task automatic t_sum_carry; // R5 carry variable added
    run("r5_sum_carry", 3'd4, 2'd1, 4'd0, 2'd1, 4'd1, 4'd3, 0, 0,
        64'h96, 16'h000B, 3, 2, 10);
  endtask

  task automatic t_consts;    // R2 constants, zero inputs
    run("r2_const_or", 3'd1, 2'd0, 4'd1, 2'd0, 4'd0, 4'd0, 0, 0,
        64'h1, 16'h0000, 0, 3, 3);
    run("r2_const_and", 3'd0, 2'd0, 4'd0, 2'd1, 4'd4, 4'd0, 0, 0,
        64'h0, 16'h0010, 1, 4, 4);
  endtask

  task automatic t_six_inputs; // R3 R10: six-variable result, start poked while busy
    logic [63:0] e;
    for (int n = 0; n < 64; n++) begin
      // index bits: v0 v1 v2 v3 v5 v7
      e[n] = (n[2] & n[4]) ^ n[1] ^ n[3] ^ n[5];
    end
    run("r10_busy_six", 3'd4, 2'd2, 4'd1, 2'd2, 4'd2, 4'd7, 1, 0,
        e, 16'h00AF, 6, 5, 66);
  endtask

  task automatic t_too_wide;  // R7 seven variables refused
    run("r7_too_wide", 3'd2, 2'd2, 4'd5, 2'd1, 4'd8, 4'd0, 0, 1,
        64'h0, 16'h0, 0, 0, 1);
    run("r7_index_kept", 3'd6, 2'd1, 4'd9, 2'd0, 4'd0, 4'd0, 0, 0,
        64'h1, 16'h0200, 1, 6, 4);
  endtask

  task automatic t_select_full; // R4 select op, R8 full repository
    run("r4_select", 3'd7, 2'd1, 4'd0, 2'd1, 4'd1, 4'd2, 0, 0,
        64'hCA, 16'h0007, 3, 7, 10);
    run("r8_full", 3'd0, 2'd0, 4'd1, 2'd0, 4'd1, 4'd0, 0, 1,
        64'h0, 16'h0, 0, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_var_and;
    t_func_xor;
    t_sum_carry;
    t_consts;
    t_six_inputs;
    t_too_wide;
    t_select_full;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R6 watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule